// File: doc/BRIEF.md
# Load Addressing-Mode Sequencer

This block runs the four load-class instructions of a 16-bit word-addressed processor, one at a time. A one-cycle `start` hands it an instruction word and the current program counter. It decodes the opcode and forms an effective address. The address is either page-relative, meaning the top seven PC bits joined to a nine-bit offset, or a base register plus a zero-extended six-bit index. It then performs zero, one or two synchronous memory reads and writes the result into an external eight-entry register file through a single write port.

Every address goes to memory through an address register. Every word read back is held in a data register before it is used, either as the final result or as the pointer for a second read. A one-cycle `done` marks the write-back. Between `start` and `done` the unit ignores new requests. The register file's read port is shared with the surrounding pipeline: the sequencer drives the base register index and reads the base value back combinationally.

Top module: `ldseq_top`

## Requirements
- R1: Opcode 4'b1110 (effective-address load) writes {PC[15:9], IR[8:0]} to the destination, raises no memory read, and pulses `done` in the 2nd cycle after the clock edge that accepts `start`.
- R2: Opcode 4'b0010 (direct load) performs exactly one read at {PC[15:9], IR[8:0]}, writes the returned word, and pulses `done` in the 4th cycle after acceptance.
- R3: Opcode 4'b1010 (indirect load) reads at {PC[15:9], IR[8:0]}, reads again at the returned word, writes the second word, performs exactly two reads, and pulses `done` in the 7th cycle after acceptance.
- R4: Opcode 4'b0110 (base load) reads at R[IR[8:6]] + zero-extended IR[5:0], wrapping modulo 2^16. `base_sel` carries IR[8:6]. It writes the returned word and pulses `done` in the 4th cycle after acceptance.
- R5: Read data is valid on `mem_rdata` one cycle after `mem_en`. `mem_addr` comes from a register loaded before the read. The word is captured in a data register before any use.
- R6: The destination register index is IR[11:9] and appears on `wr_addr` while `wr_en` is high.
- R7: `done` is high for exactly one cycle per instruction, together with `wr_en`. `wr_en` is never high at any other time.
- R8: `start` and changes on `instr`/`pc_in` are ignored from acceptance until `done`. The running instruction completes unchanged and no second instruction follows.
- R9: `start` with an opcode that is none of the four above is ignored: no read, no write, no `done`.
- R10: Synchronous active-high reset, even in mid-instruction, returns the unit to idle with `mem_en`, `wr_en` and `done` low. The next instruction then runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the instruction on `instr` |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Program counter of the instruction |
| base_sel | output | 3 | Register file read index (IR[8:6]) |
| base_val | input | 16 | Register file read data for `base_sel` |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 16 | Memory address (address register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_en` |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | 3 | Register file write index |
| wr_data | output | 16 | Register file write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets an index of 6'h3F on a base of 16'hFFF0: a design that sign-extended the index would land at 16'hFFEF instead of 16'h002F. A program counter of 16'hFFFF with offset zero catches a design that adds the offset instead of joining it to the page bits. Indirect loads check that the second address is the first returned word: a design that reused the first address, or captured data one cycle early, writes the wrong value or reads only once. Holding `start` high with a different instruction while one is running exposes a design that restarts or changes its destination. A non-load opcode and a reset in mid-instruction check that no stray read or write escapes.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int RA_W   = 3;
    localparam int OFF_W  = 9;
    localparam int IDX_W  = 6;
    localparam int PAGE_W = WORD_W - OFF_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [OPC_W-1:0] {
        OP_LEA = 4'b1110,
        OP_LD  = 4'b0010,
        OP_LDI = 4'b1010,
        OP_LDR = 4'b0110
    } ld_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_READ,
        ST_CAPT,
        ST_CHAIN,
        ST_WBACK
    } ld_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [RA_W-1:0]  dst;
        logic [OFF_W-1:0] off;
    } instr_t;

    function automatic logic is_load(input logic [OPC_W-1:0] opc);
        return (opc == OP_LEA) || (opc == OP_LD) ||
               (opc == OP_LDI) || (opc == OP_LDR);
    endfunction

    function automatic word_t page_join(input page_t pg, input logic [OFF_W-1:0] off);
        return {pg, off};
    endfunction

    function automatic word_t zext_idx(input logic [IDX_W-1:0] idx);
        return {{(WORD_W-IDX_W){1'b0}}, idx};
    endfunction

endpackage

// File: rtl/ldseq_addr.sv
module ldseq_addr
    import ldseq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  page_t            pg,
    input  logic [OFF_W-1:0] off,
    input  word_t            base,
    input  logic [IDX_W-1:0] idx,
    output word_t            ea
);

    word_t page_ea;
    word_t base_ea;

    always_comb begin
        page_ea = page_join(pg, off);
        base_ea = base + zext_idx(idx);
        ea      = (opc == OP_LDR) ? base_ea : page_ea;
    end

endmodule

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
    import ldseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OPC_W-1:0] new_opc,
    input  logic [OPC_W-1:0] cur_opc,
    output logic             ir_ld,
    output logic             mar_ld,
    output logic             mar_from_mdr,
    output logic             mdr_ld,
    output logic             mdr_from_mem,
    output logic             mem_en,
    output logic             wr_en,
    output logic             done,
    output logic             idle
);

    ld_state_e state, nxt;
    logic      pass2;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pass2 <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_CHAIN)
                pass2 <= 1'b1;
            else if (state == ST_WBACK)
                pass2 <= 1'b0;
        end
    end

    always_comb begin
        nxt          = state;
        ir_ld        = 1'b0;
        mar_ld       = 1'b0;
        mar_from_mdr = 1'b0;
        mdr_ld       = 1'b0;
        mdr_from_mem = 1'b0;
        mem_en       = 1'b0;
        wr_en        = 1'b0;
        done         = 1'b0;
        idle         = 1'b0;
        case (state)
            ST_IDLE: begin
                idle = 1'b1;
                if (start && is_load(new_opc)) begin
                    ir_ld = 1'b1;
                    nxt   = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (cur_opc == OP_LEA) begin
                    mdr_ld = 1'b1;
                    nxt    = ST_WBACK;
                end else begin
                    mar_ld = 1'b1;
                    nxt    = ST_READ;
                end
            end
            ST_READ: begin
                mem_en = 1'b1;
                nxt    = ST_CAPT;
            end
            ST_CAPT: begin
                mdr_ld       = 1'b1;
                mdr_from_mem = 1'b1;
                nxt = (cur_opc == OP_LDI && !pass2) ? ST_CHAIN : ST_WBACK;
            end
            ST_CHAIN: begin
                mar_ld       = 1'b1;
                mar_from_mdr = 1'b1;
                nxt          = ST_READ;
            end
            ST_WBACK: begin
                wr_en = 1'b1;
                done  = 1'b1;
                nxt   = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_lea_nomem_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EVAL && cur_opc == OP_LEA) |=> (done && !mem_en));

    assert_read_after_mar_R5: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> $past(mar_ld));

    assert_chain_reads_R3: assert property (@(posedge clk) disable iff (rst)
        (mar_ld && mar_from_mdr) |=> mem_en);

endmodule

// File: rtl/ldseq_dpath.sv
module ldseq_dpath
    import ldseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ir_ld,
    input  word_t instr,
    input  word_t pc_in,
    input  logic  mar_ld,
    input  logic  mar_from_mdr,
    input  logic  mdr_ld,
    input  logic  mdr_from_mem,
    input  logic  mem_en,
    input  logic  idle,
    input  word_t ea,
    input  word_t mem_rdata,
    output instr_t ir_q,
    output page_t pg_q,
    output word_t mar,
    output word_t mdr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
            pg_q <= '0;
            mar  <= '0;
            mdr  <= '0;
        end else begin
            if (ir_ld) begin
                ir_q <= instr_t'(instr);
                pg_q <= pc_in[WORD_W-1:OFF_W];
            end
            if (mar_ld)
                mar <= mar_from_mdr ? mdr : ea;
            if (mdr_ld)
                mdr <= mdr_from_mem ? mem_rdata : ea;
        end
    end

    assert_ir_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !idle |=> ($stable(ir_q) && $stable(pg_q)));

    assert_mdr_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        (mdr_ld && mdr_from_mem) |-> $past(mem_en));

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> !mar_ld);

endmodule

// File: rtl/ldseq_top.sv
module ldseq_top
    import ldseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] instr,
    input  logic [15:0] pc_in,
    output logic [2:0]  base_sel,
    input  logic [15:0] base_val,
    output logic        mem_en,
    output logic [15:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic        wr_en,
    output logic [2:0]  wr_addr,
    output logic [15:0] wr_data,
    output logic        done
);

    logic   ir_ld, mar_ld, mar_from_mdr, mdr_ld, mdr_from_mem, idle;
    instr_t ir_q;
    page_t  pg_q;
    word_t  mar, mdr, ea;

    ldseq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .new_opc      (instr[WORD_W-1 -: OPC_W]),
        .cur_opc      (ir_q.opc),
        .ir_ld        (ir_ld),
        .mar_ld       (mar_ld),
        .mar_from_mdr (mar_from_mdr),
        .mdr_ld       (mdr_ld),
        .mdr_from_mem (mdr_from_mem),
        .mem_en       (mem_en),
        .wr_en        (wr_en),
        .done         (done),
        .idle         (idle)
    );

    ldseq_addr u_addr (
        .opc  (ir_q.opc),
        .pg   (pg_q),
        .off  (ir_q.off),
        .base (base_val),
        .idx  (ir_q.off[IDX_W-1:0]),
        .ea   (ea)
    );

    ldseq_dpath u_dpath (
        .clk          (clk),
        .rst          (rst),
        .ir_ld        (ir_ld),
        .instr        (instr),
        .pc_in        (pc_in),
        .mar_ld       (mar_ld),
        .mar_from_mdr (mar_from_mdr),
        .mdr_ld       (mdr_ld),
        .mdr_from_mem (mdr_from_mem),
        .mem_en       (mem_en),
        .idle         (idle),
        .ea           (ea),
        .mem_rdata    (mem_rdata),
        .ir_q         (ir_q),
        .pg_q         (pg_q),
        .mar          (mar),
        .mdr          (mdr)
    );

    assign base_sel = ir_q.off[OFF_W-1 -: RA_W];
    assign mem_addr = mar;
    assign wr_data  = mdr;
    assign wr_addr  = ir_q.dst;

    assert_write_only_done_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

endmodule

// File: tb/ldseq_top_tb.sv
`timescale 1ns/1ps
module ldseq_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] instr, pc_in, base_val, mem_addr, mem_rdata, wr_data;
    logic [2:0]  base_sel, wr_addr;
    logic        mem_en, wr_en, done;
    logic [15:0] regs [8];

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ldseq_top u_dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in),
        .base_sel(base_sel), .base_val(base_val), .mem_en(mem_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return ({a[7:0], a[15:8]} ^ 16'h5A3C) + 16'h0101;
    endfunction

    // memory (one-cycle read) and register file models
    assign base_val = regs[base_sel];
    always @(posedge clk) begin
        if (mem_en) mem_rdata <= memf(mem_addr);
        if (rst) begin
            for (int i = 0; i < 8; i++) regs[i] <= 16'h1111 * i[15:0];
            regs[7] <= 16'hFFF0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_result(input logic [15:0] ir, input logic [15:0] pc);
        logic [15:0] pa;
        pa = {pc[15:9], ir[8:0]};
        case (ir[15:12])
            4'b1110: return pa;
            4'b0010: return memf(pa);
            4'b1010: return memf(memf(pa));
            default: return memf(regs[ir[8:6]] + {10'b0, ir[5:0]});
        endcase
    endfunction

    function automatic int exp_reads(input logic [3:0] opc);
        case (opc)
            4'b1110: return 0;
            4'b1010: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] opc);
        case (opc)
            4'b1110: return "R1";
            4'b0010: return "R2";
            4'b1010: return "R3";
            default: return "R4";
        endcase
    endfunction

    // hold_busy: keep start high with another instruction while busy (R8)
    task automatic run_one(input logic [15:0] i_ir, input logic [15:0] i_pc,
                           input int exp_lat, input bit hold_busy);
        logic [15:0] expd;
        int lat, reads;
        bit seen;
        string tg;
        tg   = op_tag(i_ir[15:12]);
        expd = exp_result(i_ir, i_pc);
        @(negedge clk);
        instr = i_ir; pc_in = i_pc; start = 1'b1;
        @(negedge clk);
        if (hold_busy) begin
            instr = 16'hE1FF; pc_in = 16'h0000;
        end else begin
            start = 1'b0;
        end
        lat = 1; reads = 0; seen = 1'b0;
        for (int k = 0; k < 20 && !seen; k++) begin
            if (mem_en) reads++;
            if (done) begin
                seen  = 1'b1;
                start = 1'b0;
                chk(wr_en === 1'b1, {tg, " R7 wr_en with done"}, {15'b0, wr_en}, 16'h1);
                chk(wr_addr === i_ir[11:9], {tg, " R6 dest index"}, {13'b0, wr_addr}, {13'b0, i_ir[11:9]});
                chk(wr_data === expd, {tg, " result"}, wr_data, expd);
                chk(lat == exp_lat, {tg, " done cycle"}, lat[15:0], exp_lat[15:0]);
            end else begin
                @(negedge clk);
                lat++;
            end
        end
        chk(seen, {tg, " done seen"}, {15'b0, seen}, 16'h1);
        chk(reads == exp_reads(i_ir[15:12]), {tg, " R5 read count"}, reads[15:0], exp_reads(i_ir[15:12]));
        @(negedge clk);
        chk(!done && !wr_en, "R7 done single cycle", {15'b0, done}, 16'h0);
    endtask

    // {instr, pc, latency}
    localparam logic [35:0] VEC [8] = '{
        {16'hE3A5, 16'h3E12, 4'd2},   // LEA R1
        {16'hE400, 16'hFFFF, 4'd2},   // LEA R2, page join not add
        {16'h26FF, 16'h8200, 4'd4},   // LD R3
        {16'h21FF, 16'h0000, 4'd4},   // LD R0
        {16'hA855, 16'h1234, 4'd7},   // LDI R4
        {16'hABC0, 16'hC000, 4'd7},   // LDI R5
        {16'h6DFF, 16'h0000, 4'd4},   // LDR R6, base R7=FFF0, idx 3F, wraps
        {16'h6445, 16'h0000, 4'd4}    // LDR R2, base R1
    };

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r0_before;
        bit stray;
        rst = 1'b1; start = 1'b0; instr = '0; pc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !wr_en && !mem_en, "R10 reset outputs", {13'b0, done, wr_en, mem_en}, 16'h0);

        foreach (VEC[i]) run_one(VEC[i][35:20], VEC[i][19:4], int'(VEC[i][3:0]), 1'b0);

        // R8: start held high with a different instruction while busy
        r0_before = regs[0];
        run_one(16'hAA11, 16'h4400, 7, 1'b0 ? 1'b0 : 1'b1);
        repeat (4) @(negedge clk);
        chk(regs[0] === r0_before && !done, "R8 busy start ignored", regs[0], r0_before);

        // R9: non-load opcode ignored
        @(negedge clk);
        instr = 16'h1234; pc_in = 16'h2000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stray = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (mem_en || wr_en || done) stray = 1'b1;
            @(negedge clk);
        end
        chk(!stray, "R9 non-load opcode ignored", {15'b0, stray}, 16'h0);

        // R10: reset mid-instruction
        @(negedge clk);
        instr = 16'hA855; pc_in = 16'h1234; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        stray = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (mem_en || wr_en || done) stray = 1'b1;
            @(negedge clk);
        end
        chk(!stray, "R10 idle after mid-run reset", {15'b0, stray}, 16'h0);
        run_one(16'hE3A5, 16'h3E12, 2, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule